// File: doc/BRIEF.md
# Interrupt Priority and Target Configuration Bank

This block is the configuration store that sits inside an interrupt distributor. For every interrupt line it keeps a priority byte and a CPU-target byte. A software-visible register interface reads and writes both arrays, four lines per 32-bit word. A third register, which is read-only, describes the block: how many lines it has and how many CPUs it serves. Each stored byte also drives a flat per-line output bus, which the downstream arbitration logic uses directly.

The interface is a single-cycle request port. A request carries a 12-bit byte address, an access size (byte, halfword or word), write data and the number of the CPU that makes the access. The address map is as follows:
- The description register sits at 0x000.
- The priority array starts at 0x400.
- The target array starts at 0x800.
- Every other location reads as zero and ignores writes.

Only the upper `PRIO_BITS` bits of each priority byte are kept. Only the target bits of CPUs that exist are kept. The first 32 lines are private to each CPU, so their target bytes are not stored. On a read, each of those bytes returns the bit of the CPU that makes the access.

Top module: `irq_cfg_bank`

## Requirements
- R1: The priority of line n is at byte address 0x400+n and its target is at 0x800+n. A word read at 0x400+4k returns line 4k in bits 7:0, line 4k+1 in bits 15:8, line 4k+2 in bits 23:16 and line 4k+3 in bits 31:24. The target array uses the same layout.
- R2: A byte access uses req_size=0. A byte write takes req_wdata[7:0] and changes only the addressed byte. A byte read returns that byte in rd_data[7:0], with rd_data[31:8] zero.
- R3: Each priority byte keeps only its upper PRIO_BITS bits, and the lower bits always read zero. With the default of 5, the stored mask is 0xF8.
- R4: In a target byte, bits at or above NUM_CPUS read zero and ignore writes. With the default of 4, the stored mask is 0x0F.
- R5: The following locations read zero and ignore writes:
  - priority or target words at or beyond NUM_LINES;
  - every address from 0xC00 upward;
  - every word of 0x000–0x3FF other than word 0.
- R6: The word at 0x000 reads NUM_CPUS-1 in bits 7:5 and NUM_LINES/32-1 in bits 4:0, with all other bits zero. The default value is 0x61. Writes to it, including all-ones, 0xA5A55A5A and zero, leave it unchanged.
- R7: The target bytes of lines 0–31 ignore writes. A read returns (1 << req_cpu) masked to the implemented CPUs in each byte. Their tgt_out bytes are zero.
- R8: Reset clears every priority and target byte to zero.
- R9: The following accesses are ignored on write and read as zero:
  - halfword accesses (req_size=1);
  - word accesses (req_size=2) with req_addr[1:0] not zero.
- R10: rd_valid and rd_data are registered. They appear one cycle after the cycle of a read request. A write changes prio_out and tgt_out one cycle after the cycle of the write request.
- R11: prio_out[8n+7:8n] and tgt_out[8n+7:8n] carry the stored priority and target of line n. They change only on a write that hits that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_wdata | input | 32 | Write data |
| req_cpu | input | 3 | Number of the CPU making the access |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| prio_out | output | NUM_LINES*8 | Per-line priority bytes |
| tgt_out | output | NUM_LINES*8 | Per-line target bytes |

## Verification
A read result is sampled by the clock edge that follows the request cycle. It is due on rd_data and rd_valid one cycle after that request. A write is likewise visible on prio_out and tgt_out one cycle after its request. The bench drives each request on a falling edge and samples on the next falling edge, which is half a period after the edge that updates the registers. A value that arrives a cycle late or a cycle early therefore shows up as a mismatch.

// File: rtl/irq_cfg_pkg.sv
// Package: shared types and helpers of the interrupt configuration bank.
// Assumes a 12-bit byte address split into four 1 KiB regions.
package irq_cfg_pkg;

    localparam int ADDR_W = 12;
    localparam int IDX_W  = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RG_DESC = 2'd0,
        RG_PRIO = 2'd1,
        RG_TGT  = 2'd2,
        RG_NONE = 2'd3
    } region_e;

    // Mask keeping the upper `bits` bits of a byte.
    function automatic logic [7:0] upper_keep(input int bits);
        return 8'(8'hFF << (8 - bits));
    endfunction

    // Mask keeping the lower `count` bits of a byte.
    function automatic logic [7:0] lower_keep(input int count);
        return 8'((16'd1 << count) - 16'd1);
    endfunction

endpackage

// File: rtl/irq_cfg_decode.sv
// Module: address and size decoder.
// Splits a request into region, word index and byte lanes. It flags legal
// sizes and alignment, and whether the word lies inside the implemented lines.
// Assumes LINES is a multiple of 32 and at most 992.
module irq_cfg_decode
    import irq_cfg_pkg::*;
#(
    parameter int LINES = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output region_e           region,
    output logic [IDX_W-1:0]  idx,
    output logic [3:0]        be,
    output logic [1:0]        lane,
    output logic              acc_ok,
    output logic              is_byte,
    output logic              in_range
);
    localparam int WORDS = LINES / 4;
    localparam logic [IDX_W:0] WORDS_L = (IDX_W+1)'(WORDS);

    acc_size_e sz;

    // Purpose: classify the access and derive its lanes.
    always_comb begin
        sz       = acc_size_e'(size);
        region   = region_e'(addr[ADDR_W-1 -: 2]);
        idx      = addr[IDX_W+1:2];
        lane     = addr[1:0];
        is_byte  = (sz == SZ_BYTE);
        acc_ok   = is_byte || ((sz == SZ_WORD) && (addr[1:0] == 2'b00));
        be       = is_byte ? (4'b0001 << addr[1:0]) : 4'b1111;
        in_range = ({1'b0, idx} < WORDS_L);
    end

endmodule

// File: rtl/irq_cfg_byte_bank.sv
// Module: per-line byte store with write masking.
// Each line owns one byte, and four lines share a 32-bit word. Only the bits
// set in KEEP are stored. Lines below FIXED_LINES have no storage and read
// zero. The write enable must already include the range and legality checks.
module irq_cfg_byte_bank
    import irq_cfg_pkg::*;
#(
    parameter int         LINES       = 64,
    parameter logic [7:0] KEEP        = 8'hFF,
    parameter int         FIXED_LINES = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     idx,
    input  logic [3:0]           be,
    input  logic [31:0]          wdata,
    output logic [31:0]          rd_word,
    output logic [LINES*8-1:0]   bytes_out
);
    localparam int WORDS = LINES / 4;

    logic [7:0] byte_q [LINES];

    genvar l;
    generate
        for (l = 0; l < LINES; l++) begin : g_line
            localparam int WI = l / 4;
            localparam int LN = l % 4;
            if (l < FIXED_LINES) begin : g_fixed
                assign byte_q[l] = 8'h00;
            end else begin : g_store
                logic [7:0] q;
                // Purpose: hold one masked byte, cleared by reset.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        q <= 8'h00;
                    end else if (wr_en && (idx == IDX_W'(WI)) && be[LN]) begin
                        q <= wdata[8*LN +: 8] & KEEP;
                    end
                end
                assign byte_q[l] = q;
            end
            assign bytes_out[8*l +: 8] = byte_q[l];
        end
    endgenerate

    // Purpose: select the addressed word for a read.
    always_comb begin
        rd_word = 32'h0;
        for (int w = 0; w < WORDS; w++) begin
            if (idx == IDX_W'(w)) begin
                rd_word = {byte_q[4*w+3], byte_q[4*w+2], byte_q[4*w+1], byte_q[4*w]};
            end
        end
    end

endmodule

// File: rtl/irq_cfg_read_path.sv
// Module: read selection and registered return.
// Picks the word of the addressed region and applies the rules for
// out-of-range and illegal accesses. A byte read returns its byte in bits
// 7:0. The result is registered once.
module irq_cfg_read_path
    import irq_cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_req,
    input  region_e     region,
    input  logic        desc_hit,
    input  logic        in_range,
    input  logic        acc_ok,
    input  logic        is_byte,
    input  logic [1:0]  lane,
    input  logic [31:0] desc_word,
    input  logic [31:0] prio_word,
    input  logic [31:0] tgt_word,
    output logic        rd_valid,
    output logic [31:0] rd_data
);
    logic [31:0] sel_word;
    logic [31:0] fmt_word;

    // Purpose: choose the region word, or zero for unbacked space.
    always_comb begin
        unique case (region)
            RG_DESC: sel_word = desc_hit ? desc_word : 32'h0;
            RG_PRIO: sel_word = in_range ? prio_word : 32'h0;
            RG_TGT:  sel_word = in_range ? tgt_word  : 32'h0;
            default: sel_word = 32'h0;
        endcase
    end

    // Purpose: apply the size rules to the selected word.
    always_comb begin
        if (!acc_ok) begin
            fmt_word = 32'h0;
        end else if (is_byte) begin
            fmt_word = {24'h0, sel_word[8*lane +: 8]};
        end else begin
            fmt_word = sel_word;
        end
    end

    // Purpose: register the read result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 32'h0;
        end else begin
            rd_valid <= rd_req;
            rd_data  <= rd_req ? fmt_word : 32'h0;
        end
    end

endmodule

// File: rtl/irq_cfg_bank.sv
// Module: interrupt priority and target configuration bank (top).
// Holds a priority byte and a target byte per line, plus a read-only
// description word at 0x000. The target bytes of the first 32 lines are
// private to each CPU: they are not stored and read back the bit of the CPU
// making the access. Assumes NUM_LINES is a multiple of 32 up to 992,
// NUM_CPUS is 1..8 and PRIO_BITS is 4..8.
module irq_cfg_bank
    import irq_cfg_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4,
    parameter int PRIO_BITS = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [11:0]            req_addr,
    input  logic [1:0]             req_size,
    input  logic [31:0]            req_wdata,
    input  logic [2:0]             req_cpu,
    output logic                   rd_valid,
    output logic [31:0]            rd_data,
    output logic [NUM_LINES*8-1:0] prio_out,
    output logic [NUM_LINES*8-1:0] tgt_out
);
    localparam int         PRIVATE_LINES = 32;
    localparam int         PRIVATE_WORDS = PRIVATE_LINES / 4;
    localparam logic [7:0] PRIO_KEEP     = upper_keep(PRIO_BITS);
    localparam logic [7:0] CPU_KEEP      = lower_keep(NUM_CPUS);
    localparam logic [31:0] DESC_WORD    =
        {24'h0, 3'(NUM_CPUS - 1), 5'(NUM_LINES / 32 - 1)};

    region_e          region;
    logic [IDX_W-1:0] idx;
    logic [3:0]       be;
    logic [1:0]       lane;
    logic             acc_ok;
    logic             is_byte;
    logic             in_range;
    logic             wr_ok;
    logic             prio_we;
    logic             tgt_we;
    logic [31:0]      wr_word;
    logic [31:0]      prio_rd;
    logic [31:0]      tgt_rd;
    logic [31:0]      tgt_sel;
    logic [7:0]       own_bit;

    irq_cfg_decode #(.LINES(NUM_LINES)) u_dec (
        .addr     (req_addr),
        .size     (req_size),
        .region   (region),
        .idx      (idx),
        .be       (be),
        .lane     (lane),
        .acc_ok   (acc_ok),
        .is_byte  (is_byte),
        .in_range (in_range)
    );

    // Purpose: gate writes to the arrays and replicate byte data to all lanes.
    always_comb begin
        wr_ok   = req_valid && req_write && acc_ok && in_range;
        prio_we = wr_ok && (region == RG_PRIO);
        tgt_we  = wr_ok && (region == RG_TGT);
        wr_word = is_byte ? {4{req_wdata[7:0]}} : req_wdata;
    end

    irq_cfg_byte_bank #(
        .LINES       (NUM_LINES),
        .KEEP        (PRIO_KEEP),
        .FIXED_LINES (0)
    ) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (prio_we),
        .idx       (idx),
        .be        (be),
        .wdata     (wr_word),
        .rd_word   (prio_rd),
        .bytes_out (prio_out)
    );

    irq_cfg_byte_bank #(
        .LINES       (NUM_LINES),
        .KEEP        (CPU_KEEP),
        .FIXED_LINES (PRIVATE_LINES)
    ) u_tgt (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tgt_we),
        .idx       (idx),
        .be        (be),
        .wdata     (wr_word),
        .rd_word   (tgt_rd),
        .bytes_out (tgt_out)
    );

    // Purpose: substitute the accessing CPU's bit for the private target words.
    always_comb begin
        own_bit = (8'h01 << req_cpu) & CPU_KEEP;
        tgt_sel = (idx < IDX_W'(PRIVATE_WORDS)) ? {4{own_bit}} : tgt_rd;
    end

    irq_cfg_read_path u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (req_valid && !req_write),
        .region    (region),
        .desc_hit  (idx == '0),
        .in_range  (in_range),
        .acc_ok    (acc_ok),
        .is_byte   (is_byte),
        .lane      (lane),
        .desc_word (DESC_WORD),
        .prio_word (prio_rd),
        .tgt_word  (tgt_sel),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/irq_cfg_bank_chk.sv
// Module: assertion checker for irq_cfg_bank, attached with bind.
// It observes the ports only.
module irq_cfg_bank_chk #(
    parameter int NUM_LINES = 64,
    parameter int NUM_CPUS  = 4,
    parameter int PRIO_BITS = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_write,
    input logic [11:0]            req_addr,
    input logic [1:0]             req_size,
    input logic                   rd_valid,
    input logic [31:0]            rd_data,
    input logic [NUM_LINES*8-1:0] prio_out,
    input logic [NUM_LINES*8-1:0] tgt_out
);
    localparam logic [7:0]  P_KEEP = 8'(8'hFF << (8 - PRIO_BITS));
    localparam logic [7:0]  T_KEEP = 8'((16'd1 << NUM_CPUS) - 16'd1);
    localparam logic [31:0] DESC   =
        {24'h0, 3'(NUM_CPUS - 1), 5'(NUM_LINES / 32 - 1)};

    logic [7:0] prio_low;
    logic [7:0] tgt_high;
    logic [7:0] private_tgt;

    // Purpose: collect bits that must never be set on the per-line outputs.
    always_comb begin
        prio_low    = 8'h0;
        tgt_high    = 8'h0;
        private_tgt = 8'h0;
        for (int n = 0; n < NUM_LINES; n++) begin
            prio_low = prio_low | (prio_out[8*n +: 8] & ~P_KEEP);
            tgt_high = tgt_high | (tgt_out[8*n +: 8] & ~T_KEEP);
            if (n < 32) private_tgt = private_tgt | tgt_out[8*n +: 8];
        end
    end

    // R3: the unimplemented priority bits stay zero
    a_r3_prio_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        prio_low == 8'h0);

    // R4: the target bits of absent CPUs stay zero
    a_r4_tgt_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_high == 8'h0);

    // R7: the private target lines drive zero downstream
    a_r7_private_zero: assert property (@(posedge clk) disable iff (!rst_n)
        private_tgt == 8'h0);

    // R10: a read request returns valid data in the next cycle
    a_r10_rd_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R10: rd_valid is raised only by a read request in the cycle before
    a_r10_rd_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    // R11: the outputs hold while no write is made
    a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> ($stable(prio_out) && $stable(tgt_out)));

    // R9: a halfword access changes nothing
    a_r9_half_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd1) |=> ($stable(prio_out) && $stable(tgt_out)));

    // R9: a halfword read returns zero
    a_r9_half_raz: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_size == 2'd1) |=> (rd_data == 32'h0));

    // R6: a word read of the description register returns its constant value
    a_r6_desc_value: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 12'h000 && req_size == 2'd2)
        |=> (rd_data == DESC));

    // R5: the top region reads zero
    a_r5_top_raz: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr[11:10] == 2'b11) |=> (rd_data == 32'h0));

endmodule

bind irq_cfg_bank irq_cfg_bank_chk #(
    .NUM_LINES (NUM_LINES),
    .NUM_CPUS  (NUM_CPUS),
    .PRIO_BITS (PRIO_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .prio_out  (prio_out),
    .tgt_out   (tgt_out)
);

// File: tb/test_irq_cfg_bank.sv
// Directed bench for irq_cfg_bank with the default parameters
// (64 lines, 4 CPUs, 5 priority bits).
module test_irq_cfg_bank;

    localparam int LINES = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [11:0]       req_addr = '0;
    logic [1:0]        req_size = 2'd2;
    logic [31:0]       req_wdata = '0;
    logic [2:0]        req_cpu = '0;
    logic              rd_valid;
    logic [31:0]       rd_data;
    logic [LINES*8-1:0] prio_out;
    logic [LINES*8-1:0] tgt_out;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    irq_cfg_bank i_irq_cfg_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .req_cpu   (req_cpu),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .prio_out  (prio_out),
        .tgt_out   (tgt_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=20000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: act=%08h exp=%08h", req, act, exp);
        end
    endtask

    // Called on a falling edge. Issues one write and returns on the next falling edge.
    task automatic wr(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Called on a falling edge. Issues one read and samples the registered result.
    task automatic rd(input logic [11:0] a, input logic [1:0] sz, input logic [2:0] cpu,
                      output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz; req_cpu = cpu;
        @(negedge clk);
        d = rd_data;
        check("R10 rd_valid", {31'h0, rd_valid}, 32'h1);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R8 prio_out after reset", {31'h0, |prio_out}, 32'h0);
        check("R8 tgt_out after reset", {31'h0, |tgt_out}, 32'h0);
        rd(12'h420, 2'd2, 3'd0, d); check("R8 prio word", d, 32'h0);
        rd(12'h860, 2'd2, 3'd0, d); check("R8 tgt word", d, 32'h0);
    endtask

    task automatic t_prio;
        logic [31:0] d;
        wr(12'h420, 2'd2, 32'hFF7FBF3F);
        check("R10 R11 prio_out line32 next cycle", {24'h0, prio_out[32*8 +: 8]}, 32'h38);
        check("R11 prio_out line35", {24'h0, prio_out[35*8 +: 8]}, 32'hF8);
        rd(12'h420, 2'd2, 3'd0, d); check("R1 R3 prio word", d, 32'hF878B838);
        wr(12'h43C, 2'd2, 32'hFFFFFFFF);
        rd(12'h43C, 2'd2, 3'd0, d); check("R3 last prio word", d, 32'hF8F8F8F8);
        check("R11 prio_out line63", {24'h0, prio_out[63*8 +: 8]}, 32'hF8);
    endtask

    task automatic t_byte;
        logic [31:0] d;
        wr(12'h422, 2'd0, 32'hFFFFFF1F);
        rd(12'h420, 2'd2, 3'd0, d); check("R2 byte write one lane", d, 32'hF818B838);
        rd(12'h421, 2'd0, 3'd0, d); check("R2 byte read", d, 32'h000000B8);
        check("R11 prio_out line34", {24'h0, prio_out[34*8 +: 8]}, 32'h18);
    endtask

    task automatic t_tgt;
        logic [31:0] d;
        wr(12'h820, 2'd2, 32'h0103020F);
        rd(12'h820, 2'd2, 3'd0, d); check("R1 tgt word", d, 32'h0103020F);
        check("R11 tgt_out line33", {24'h0, tgt_out[33*8 +: 8]}, 32'h02);
        wr(12'h824, 2'd2, 32'hFFFFFFFF);
        rd(12'h824, 2'd2, 3'd0, d); check("R4 tgt cpu mask", d, 32'h0F0F0F0F);
        wr(12'h825, 2'd0, 32'h00000013);
        rd(12'h824, 2'd2, 3'd0, d); check("R4 R2 tgt byte write", d, 32'h0F0F030F);
    endtask

    task automatic t_private;
        logic [31:0] d;
        rd(12'h800, 2'd2, 3'd2, d); check("R7 private read cpu2", d, 32'h04040404);
        rd(12'h81C, 2'd2, 3'd0, d); check("R7 private read cpu0", d, 32'h01010101);
        rd(12'h800, 2'd2, 3'd5, d); check("R7 absent cpu5", d, 32'h0);
        wr(12'h800, 2'd2, 32'hFFFFFFFF);
        check("R7 private tgt_out", {24'h0, tgt_out[7:0]}, 32'h0);
        rd(12'h803, 2'd0, 3'd3, d); check("R7 private byte cpu3", d, 32'h08);
    endtask

    task automatic t_range;
        logic [31:0] d;
        logic [LINES*8-1:0] p0, t0;
        p0 = prio_out; t0 = tgt_out;
        wr(12'h440, 2'd2, 32'hFFFFFFFF);
        wr(12'h840, 2'd2, 32'hFFFFFFFF);
        wr(12'hC00, 2'd2, 32'hFFFFFFFF);
        check("R5 prio_out untouched", {31'h0, prio_out == p0}, 32'h1);
        check("R5 tgt_out untouched", {31'h0, tgt_out == t0}, 32'h1);
        rd(12'h440, 2'd2, 3'd0, d); check("R5 prio beyond lines", d, 32'h0);
        rd(12'h840, 2'd2, 3'd0, d); check("R5 tgt beyond lines", d, 32'h0);
        rd(12'hC00, 2'd2, 3'd0, d); check("R5 top region", d, 32'h0);
        rd(12'h004, 2'd2, 3'd0, d); check("R5 desc region word1", d, 32'h0);
    endtask

    task automatic t_desc;
        logic [31:0] d;
        wr(12'h000, 2'd2, 32'hFFFFFFFF);
        rd(12'h000, 2'd2, 3'd0, d); check("R6 after all-ones", d, 32'h00000061);
        wr(12'h000, 2'd2, 32'hA5A55A5A);
        rd(12'h000, 2'd2, 3'd0, d); check("R6 after A5A55A5A", d, 32'h00000061);
        wr(12'h000, 2'd2, 32'h0);
        rd(12'h000, 2'd2, 3'd0, d); check("R6 after zero", d, 32'h00000061);
    endtask

    task automatic t_half;
        logic [31:0] d;
        wr(12'h420, 2'd1, 32'h0);
        rd(12'h420, 2'd2, 3'd0, d); check("R9 halfword write ignored", d, 32'hF818B838);
        rd(12'h420, 2'd1, 3'd0, d); check("R9 halfword read zero", d, 32'h0);
        wr(12'h421, 2'd2, 32'h0);
        rd(12'h420, 2'd2, 3'd0, d); check("R9 misaligned write ignored", d, 32'hF818B838);
        rd(12'h422, 2'd2, 3'd0, d); check("R9 misaligned read zero", d, 32'h0);
        @(negedge clk);
        check("R10 rd_valid drops when idle", {31'h0, rd_valid}, 32'h0);
    endtask

    task automatic t_reset_again;
        logic [31:0] d;
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 prio cleared by reset", {31'h0, |prio_out}, 32'h0);
        check("R8 tgt cleared by reset", {31'h0, |tgt_out}, 32'h0);
        rd(12'h820, 2'd2, 3'd0, d); check("R8 tgt word cleared", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prio();
        t_byte();
        t_tgt();
        t_private();
        t_range();
        t_desc();
        t_half();
        t_reset_again();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule